// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Controller

This block runs single external machine cycles on a byte-wide bus. The low address byte shares its pins with the data byte, and the top address nibble shares its pins with cycle status. A request is one pulse on `start`, with the direction, the memory/I/O choice, the operand width, the address and the write data presented alongside it. The controller steps through an address phase, in which it raises an address strobe for one cycle so that external logic can capture the low address. It then runs a data phase with active-low read or write strobes and returns the read data with a one-cycle `done` pulse.

The cycle states are named ST_IDLE, ST_T1, ST_T2, ST_T3, ST_TW and ST_T4. The transitions are as follows. ST_IDLE goes to ST_T1 on `start`. ST_T1 goes to ST_T2 unconditionally, and ST_T2 goes to ST_T3 unconditionally. ST_T3 goes to ST_T4 when `rdy` is high and to ST_TW when it is low. ST_TW stays in ST_TW while `rdy` is low and goes to ST_T4 when it is high. ST_T4 goes back to ST_T1 for the second byte of a 16-bit operand, and to ST_IDLE otherwise. A built-in demultiplexing latch gives a stable copy of the low address byte for the rest of each cycle.

Top module: `mux_bus_cycle_ctrl`

## Requirements
- R1: After reset, and in ST_IDLE, `ale`=0, `rd_n`=1, `wr_n`=1, `ad_oe`=0, `ad_out`=0, `a_mid`=0, `as_out`=0, `io_m`=0, `busy`=0 and `done`=0. After reset `lat_addr`=0 and `rdata`=0.
- R2: In ST_T1, `ale`=1 for exactly one cycle, `ad_oe`=1, `rd_n`=`wr_n`=1, and `ad_out` carries bits 7:0 of the byte address.
- R3: For a read, in ST_T2, ST_T3, ST_TW and ST_T4, `rd_n`=0, `wr_n`=1, `ad_oe`=0 and `ad_out`=0.
- R4: For a write, in ST_T2, ST_T3, ST_TW and ST_T4, `wr_n`=0, `rd_n`=1, `ad_oe`=1 and `ad_out` carries the write byte. `rd_n` and `wr_n` are never low together.
- R5: `a_mid` carries byte-address bits 15:8 in every state from ST_T1 through ST_T4.
- R6: `as_out` carries byte-address bits 19:16 in ST_T1 for a memory cycle and 0 for an I/O cycle. From ST_T2 to ST_T4 it carries status: bit 3 = 0, bit 2 = I/O, bit 1 = write, bit 0 = byte index.
- R7: `rdy` is sampled at the end of ST_T3 and of each ST_TW. While it is low, another ST_TW follows, with all pins held.
- R8: On the clock edge that ends the last ST_T4, `done` rises for one cycle. For a read, `rdata` takes `ad_in` as sampled at the end of each ST_T4: {8'h00, byte0} for an 8-bit read and {byte1, byte0} for a 16-bit read. A write leaves `rdata` unchanged.
- R9: A 16-bit operand (`req_wide`=1) runs as two full byte cycles, low byte first. The second byte uses address+1: wrapping in 20 bits for memory, and wrapping in the low 16 bits for I/O, with the top nibble 0. Write bytes are `req_wdata[7:0]` then `req_wdata[15:8]`.
- R10: A `start` pulse while `busy`=1 is ignored. The running cycle completes unchanged and no new cycle follows.
- R11: `lat_addr` follows `ad_out` while `ale`=1 and holds the captured low address byte after `ale` falls.
- R12: `io_m` equals the request's I/O flag in ST_T1 through ST_T4. `busy`=1 in every non-idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, taken in ST_IDLE only |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| req_wide | input | 1 | 1 = 16-bit operand (two byte cycles) |
| req_addr | input | 20 | Byte address (low 16 bits used for I/O) |
| req_wdata | input | 16 | Write data, low byte first |
| rdy | input | 1 | External ready, low inserts wait states |
| ad_in | input | 8 | Data sampled from the shared low lines |
| ad_out | output | 8 | Value driven on the shared low lines |
| ad_oe | output | 1 | Drive enable for the shared low lines |
| a_mid | output | 8 | Address bits 15:8 |
| as_out | output | 4 | Address bits 19:16 or cycle status |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_m | output | 1 | 1 = I/O target, 0 = memory |
| lat_addr | output | 8 | Demultiplexed low address byte |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read result |

## Verification
The interesting coincidences are a stray `start` arriving in the same cycle as a running data phase, and a wait state falling in the same cycle as the boundary between the two bytes of a 16-bit operand. The first is provoked by raising `start` with a different address during ST_T2. It is judged by comparing every pin in every following cycle against the original request, and then confirming that the block stays idle. The second is provoked by random wait counts on each byte of wide transfers. It is judged by checking that the second ST_T1 comes only after the first byte's ST_T4, with the incremented address.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_T3   = 3'd3,
        ST_TW   = 3'd4,
        ST_T4   = 3'd5
    } cyc_state_e;

    typedef struct packed {
        logic write;
        logic io;
        logic wide;
    } cyc_kind_t;

endpackage

// File: rtl/mbc_seq_fsm.sv
module mbc_seq_fsm
    import mbc_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  cyc_kind_t             kind_in,
    input  logic [ADDR_W-1:0]     addr_in,
    input  logic [2*DATA_W-1:0]   wdata_in,
    input  logic                  rdy,
    input  logic [DATA_W-1:0]     ad_in,
    output cyc_state_e            state,
    output logic                  byte_idx,
    output cyc_kind_t             kind,
    output logic [ADDR_W-1:0]     byte_addr,
    output logic [DATA_W-1:0]     wbyte,
    output logic                  busy,
    output logic                  done,
    output logic [2*DATA_W-1:0]   rdata
);

    localparam int IO_W = 2 * DATA_W;
    localparam int HI_W = ADDR_W - IO_W;

    cyc_state_e              state_nx;
    logic [ADDR_W-1:0]       base_addr;
    logic [2*DATA_W-1:0]     wdata_q;
    logic [DATA_W-1:0]       rd_lo;
    logic [IO_W-1:0]         io_addr;
    logic                    last_byte;

    assign last_byte = !kind.wide || byte_idx;
    assign busy      = (state != ST_IDLE);

    // state transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_T1;
            ST_T1:   state_nx = ST_T2;
            ST_T2:   state_nx = ST_T3;
            ST_T3:   state_nx = rdy ? ST_T4 : ST_TW;
            ST_TW:   state_nx = rdy ? ST_T4 : ST_TW;
            ST_T4:   state_nx = last_byte ? ST_IDLE : ST_T1;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // request capture and byte sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr <= '0;
            wdata_q   <= '0;
            kind      <= '0;
            byte_idx  <= 1'b0;
        end else if (state == ST_IDLE && start) begin
            base_addr <= addr_in;
            wdata_q   <= wdata_in;
            kind      <= kind_in;
            byte_idx  <= 1'b0;
        end else if (state == ST_T4 && !last_byte) begin
            byte_idx  <= 1'b1;
        end
    end

    assign io_addr   = base_addr[IO_W-1:0] + IO_W'(byte_idx);
    assign byte_addr = kind.io ? {{HI_W{1'b0}}, io_addr}
                               : base_addr + ADDR_W'(byte_idx);
    assign wbyte     = byte_idx ? wdata_q[2*DATA_W-1:DATA_W] : wdata_q[DATA_W-1:0];

    // read capture and completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_lo <= '0;
            rdata <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state == ST_T4) begin
                if (last_byte) done <= 1'b1;
                if (!kind.write) begin
                    if (!byte_idx) rd_lo <= ad_in;
                    if (last_byte) begin
                        if (kind.wide) rdata <= {ad_in, rd_lo};
                        else           rdata <= {{DATA_W{1'b0}}, ad_in};
                    end
                end
            end
        end
    end

    AST_WAIT_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_T3 || state == ST_TW) && !rdy) |=> (state == ST_TW)); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_REQ_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(base_addr)); // R10
    AST_WIDE_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_T4 && kind.wide && !byte_idx) |=> (state == ST_T1 && byte_idx)); // R9

endmodule

// File: rtl/mbc_pin_mux.sv
module mbc_pin_mux
    import mbc_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  cyc_state_e            state,
    input  cyc_kind_t             kind,
    input  logic                  byte_idx,
    input  logic [ADDR_W-1:0]     byte_addr,
    input  logic [DATA_W-1:0]     wbyte,
    output logic                  ale,
    output logic                  rd_n,
    output logic                  wr_n,
    output logic                  ad_oe,
    output logic [DATA_W-1:0]     ad_out,
    output logic [DATA_W-1:0]     a_mid,
    output logic [ADDR_W-2*DATA_W-1:0] as_out,
    output logic                  io_m
);

    localparam int IO_W = 2 * DATA_W;
    localparam int HI_W = ADDR_W - IO_W;

    logic [HI_W-1:0] status;

    always_comb begin
        status    = '0;
        status[2] = kind.io;
        status[1] = kind.write;
        status[0] = byte_idx;
    end

    always_comb begin
        ale    = 1'b0;
        rd_n   = 1'b1;
        wr_n   = 1'b1;
        ad_oe  = 1'b0;
        ad_out = '0;
        a_mid  = '0;
        as_out = '0;
        io_m   = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_T1: begin
                ale    = 1'b1;
                ad_oe  = 1'b1;
                ad_out = byte_addr[DATA_W-1:0];
                a_mid  = byte_addr[IO_W-1:DATA_W];
                as_out = kind.io ? '0 : byte_addr[ADDR_W-1:IO_W];
                io_m   = kind.io;
            end
            ST_T2, ST_T3, ST_TW, ST_T4: begin
                a_mid  = byte_addr[IO_W-1:DATA_W];
                as_out = status;
                io_m   = kind.io;
                rd_n   = kind.write;
                wr_n   = !kind.write;
                ad_oe  = kind.write;
                ad_out = kind.write ? wbyte : '0;
            end
            default: ;
        endcase
    end

    AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale); // R2
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n)); // R4
    AST_READ_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe); // R3

endmodule

// File: rtl/mbc_addr_latch.sv
module mbc_addr_latch #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);

    logic [DATA_W-1:0] held;

    always_ff @(posedge clk) begin
        if (!rst_n)   held <= '0;
        else if (ale) held <= d;
    end

    assign q = ale ? d : held;

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ale) |-> (q == $past(d))); // R11

endmodule

// File: rtl/mux_bus_cycle_ctrl.sv
module mux_bus_cycle_ctrl
    import mbc_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic                         req_write,
    input  logic                         req_io,
    input  logic                         req_wide,
    input  logic [ADDR_W-1:0]            req_addr,
    input  logic [2*DATA_W-1:0]          req_wdata,
    input  logic                         rdy,
    input  logic [DATA_W-1:0]            ad_in,
    output logic [DATA_W-1:0]            ad_out,
    output logic                         ad_oe,
    output logic [DATA_W-1:0]            a_mid,
    output logic [ADDR_W-2*DATA_W-1:0]   as_out,
    output logic                         ale,
    output logic                         rd_n,
    output logic                         wr_n,
    output logic                         io_m,
    output logic [DATA_W-1:0]            lat_addr,
    output logic                         busy,
    output logic                         done,
    output logic [2*DATA_W-1:0]          rdata
);

    cyc_state_e        state;
    cyc_kind_t         kind_in;
    cyc_kind_t         kind;
    logic              byte_idx;
    logic [ADDR_W-1:0] byte_addr;
    logic [DATA_W-1:0] wbyte;

    assign kind_in = '{write: req_write, io: req_io, wide: req_wide};

    mbc_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .kind_in(kind_in),
        .addr_in(req_addr), .wdata_in(req_wdata), .rdy(rdy), .ad_in(ad_in),
        .state(state), .byte_idx(byte_idx), .kind(kind), .byte_addr(byte_addr),
        .wbyte(wbyte), .busy(busy), .done(done), .rdata(rdata)
    );

    mbc_pin_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .clk(clk), .rst_n(rst_n), .state(state), .kind(kind), .byte_idx(byte_idx),
        .byte_addr(byte_addr), .wbyte(wbyte), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
        .ad_oe(ad_oe), .ad_out(ad_out), .a_mid(a_mid), .as_out(as_out), .io_m(io_m)
    );

    mbc_addr_latch #(.DATA_W(DATA_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .ale(ale), .d(ad_out), .q(lat_addr)
    );

    AST_IO_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy) |-> (!io_m && rd_n && wr_n && !ale)); // R12

endmodule

// File: tb/mux_bus_cycle_ctrl_tb_top.sv
`timescale 1ns/1ps
module mux_bus_cycle_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        req_write = 1'b0, req_io = 1'b0, req_wide = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        rdy = 1'b1;
    logic [7:0]  ad_in = '0;
    logic [7:0]  ad_out, a_mid, lat_addr;
    logic        ad_oe, ale, rd_n, wr_n, io_m, busy, done;
    logic [3:0]  as_out;
    logic [15:0] rdata;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    logic [15:0] exp_rdata = '0;
    logic [7:0]  exp_lat = '0;

    always #2 clk = ~clk;

    mux_bus_cycle_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .req_write(req_write),
        .req_io(req_io), .req_wide(req_wide), .req_addr(req_addr),
        .req_wdata(req_wdata), .rdy(rdy), .ad_in(ad_in), .ad_out(ad_out),
        .ad_oe(ad_oe), .a_mid(a_mid), .as_out(as_out), .ale(ale), .rd_n(rd_n),
        .wr_n(wr_n), .io_m(io_m), .lat_addr(lat_addr), .busy(busy),
        .done(done), .rdata(rdata)
    );

    // packed view: ale rd_n wr_n ad_oe io_m busy done | ad_out | a_mid | as_out | lat_addr
    function automatic logic [35:0] pins_now();
        return {ale, rd_n, wr_n, ad_oe, io_m, busy, done, ad_out, a_mid, as_out, lat_addr};
    endfunction

    function automatic logic [35:0] exp_idle(logic dn, logic [7:0] lat);
        return {1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, dn, 8'h00, 8'h00, 4'h0, lat};
    endfunction

    function automatic logic [35:0] exp_t1(logic io, logic [19:0] ba);
        return {1'b1, 1'b1, 1'b1, 1'b1, io, 1'b1, 1'b0, ba[7:0], ba[15:8],
                io ? 4'h0 : ba[19:16], ba[7:0]};
    endfunction

    function automatic logic [35:0] exp_data(logic wr, logic io, logic b,
                                             logic [19:0] ba, logic [7:0] wb);
        return {1'b0, wr, !wr, wr, io, 1'b1, 1'b0, wr ? wb : 8'h00, ba[15:8],
                {1'b0, io, wr, b}, ba[7:0]};
    endfunction

    function automatic logic [19:0] byte_address(logic io, logic [19:0] a, int b);
        if (io) return {4'h0, a[15:0] + 16'(b)};
        return a + 20'(b);
    endfunction

    task automatic check(string tag, logic [35:0] act, logic [35:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check16(string tag, logic [15:0] act, logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_txn(logic wr, logic io, logic wide, logic [19:0] addr,
                           logic [15:0] wd, int w0, int w1, bit poke);
        logic [7:0] rb0 = 8'h00;
        @(negedge clk);
        start = 1'b1; req_write = wr; req_io = io; req_wide = wide;
        req_addr = addr; req_wdata = wd;
        @(negedge clk);
        start = 1'b0;
        for (int b = 0; b <= (wide ? 1 : 0); b++) begin
            logic [19:0] ba = byte_address(io, addr, b);
            logic [7:0]  wb = (b == 1) ? wd[15:8] : wd[7:0];
            logic [7:0]  rb = 8'($urandom);
            int          waits = (b == 1) ? w1 : w0;
            ad_in = rb;
            check("T1 R2 R5 R6 R11 R12", pins_now(), exp_t1(io, ba));
            @(negedge clk);
            rdy = (waits == 0);
            if (poke && b == 0) begin
                start = 1'b1; req_addr = ~addr; req_write = ~wr; req_io = ~io;
            end
            check(wr ? "T2 R4 R5 R6 R11" : "T2 R3 R5 R6 R11", pins_now(),
                  exp_data(wr, io, 1'(b), ba, wb));
            @(negedge clk);
            start = 1'b0;
            check(poke ? "T3 R10 R6" : "T3 R3 R4 R6", pins_now(),
                  exp_data(wr, io, 1'(b), ba, wb));
            for (int w = 1; w <= waits; w++) begin
                @(negedge clk);
                rdy = (w == waits);
                check("TW R7", pins_now(), exp_data(wr, io, 1'(b), ba, wb));
            end
            @(negedge clk);
            check("T4 R3 R4 R9", pins_now(), exp_data(wr, io, 1'(b), ba, wb));
            if (b == 0) rb0 = rb;
            else if (!wr) exp_rdata = {rb, rb0};
            exp_lat = ba[7:0];
            @(negedge clk);
        end
        if (!wr && !wide) exp_rdata = {8'h00, rb0};
        check("end R8 R1", pins_now(), exp_idle(1'b1, exp_lat));
        check16("rdata R8 R9", rdata, exp_rdata);
        if (poke) begin
            @(negedge clk);
            check("after R10 R8", pins_now(), exp_idle(1'b0, exp_lat));
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        check("reset R1", pins_now(), exp_idle(1'b0, 8'h00));
        check16("reset rdata R1", rdata, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("idle R1", pins_now(), exp_idle(1'b0, 8'h00));
        // directed corners
        run_txn(1'b0, 1'b0, 1'b0, 20'hA5C3E, 16'h0000, 0, 0, 1'b0);
        run_txn(1'b1, 1'b0, 1'b0, 20'h12345, 16'h00B7, 2, 0, 1'b0);
        run_txn(1'b0, 1'b0, 1'b1, 20'hFFFFF, 16'h0000, 1, 3, 1'b0); // R9 20-bit wrap
        run_txn(1'b1, 1'b1, 1'b1, 20'h3FFFF, 16'hC0DE, 0, 2, 1'b0); // R9 I/O 16-bit wrap
        run_txn(1'b0, 1'b1, 1'b0, 20'hF8123, 16'h0000, 3, 0, 1'b0); // R6 I/O top zero
        run_txn(1'b1, 1'b0, 1'b0, 20'h0BEEF, 16'h0055, 1, 0, 1'b1); // R10
        run_txn(1'b0, 1'b0, 1'b1, 20'h40000, 16'h0000, 0, 0, 1'b1); // R10 wide
        // constrained random
        for (int i = 0; i < 40; i++) begin
            logic [31:0] r = $urandom;
            run_txn(r[0], r[1], r[2], 20'($urandom), 16'($urandom),
                    int'(r[5:4]), int'(r[7:6]), r[11:8] == 4'h0);
        end
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R7: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule